// File: doc/BRIEF.md
# Three-Wire Codec Control Master

This block drives a three-wire codec control bus made of a mode line, a serial clock line and a serial data line. Software or a sequencer hands it a command one byte beat at a time over a valid/ready handshake. The first beat of a command names a register selector. The block builds the address byte from a fixed device code and that selector, and shifts it out while the mode line is low. Each later beat carries one data byte, a flag that asks for a halt before the byte, and a flag that marks the final byte. Data bytes are shifted out while the mode line is high.

Every bit is sent LSB first as a clock-low half followed by a clock-high half, and the data line is held for both halves. The setup interval before a byte or a halt and the length of each clock half are parameters counted in system clocks. The defaults are 20 and 50, which give 200 ns and 500 ns at a 100 MHz clock. `busy` covers a whole command. `done` pulses once when the lines are back at rest after the last byte.

Top module: `ctl3_master`

## Requirements
- R1: After reset, and whenever no command is in progress, line_mode=1, line_clk=1, line_data=0, cmd_ready=1, busy=0 and done=0.
- R2: In the cycle after a first beat is accepted, the lines show mode=0, clk=1, data=0 for exactly SETUP_CYC cycles before the first address bit.
- R3: The address byte equals {DEV_CODE, cmd_data[1:0]}, with DEV_CODE (default 6'b000101) in bits 7:2 and the selector in bits 1:0 (00 picks data register 0, 10 picks the status register). cmd_data[7:2], cmd_halt and cmd_last on the first beat have no effect.
- R4: Each byte is sent as eight bits, bit 0 first. For each bit, clk is low for exactly HALF_CYC cycles and then high for exactly HALF_CYC cycles, with line_data equal to the bit throughout both halves.
- R5: line_mode is 0 during all address bits and 1 during all data bits.
- R6: After the address byte or a data byte that is not the final one, the lines rest at mode=1, clk=1, data=0 with cmd_ready=1 and busy=1, and they hold those levels for as long as no beat arrives.
- R7: A data beat with cmd_halt=1 produces mode=0, clk=1, data=0 for SETUP_CYC cycles and then mode=1, clk=1, data=0 for SETUP_CYC cycles before its first bit. With cmd_halt=0, only the mode-high setup of SETUP_CYC cycles comes before the first bit.
- R8: After the last high half of a beat flagged cmd_last, done is 1 for exactly one cycle while the lines are at rest and busy=1. In the following cycle the block is idle as in R1.
- R9: cmd_ready is 0 during every setup, halt and bit interval. A beat offered during those intervals is not taken and does not change the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Beat offered |
| cmd_ready | output | 1 | Beat can be taken this cycle |
| cmd_data | input | 8 | Selector (first beat, bits 1:0) or data byte |
| cmd_halt | input | 1 | Insert a halt before this data byte |
| cmd_last | input | 1 | This data byte ends the command |
| line_mode | output | 1 | Bus mode line |
| line_clk | output | 1 | Bus serial clock |
| line_data | output | 1 | Bus serial data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |

## Verification
The assertions assume that a command follows the beat protocol: a first beat while idle, then data beats until one carries cmd_last. Under that assumption, any movement of the serial clock must come from an expired phase counter, and the shifter is never stepped beyond its eighth bit. The stimulus keeps to this protocol. Every command it sends ends with a flagged beat. It also offers stray beats only while cmd_ready is low, and withdraws them before the resting interval that follows the address, so those beats test R9 without starting a new transfer.

// File: rtl/ctl3_pkg.sv
package ctl3_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int DEV_W  = BYTE_W - SEL_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASETUP,
        ST_BLO,
        ST_BHI,
        ST_GAP,
        ST_HALT,
        ST_DSETUP,
        ST_FIN
    } ctl3_state_e;

    typedef struct packed {
        logic mode;
        logic sclk;
        logic sdat;
    } ctl3_lines_t;

    localparam ctl3_lines_t LINES_REST = '{mode: 1'b1, sclk: 1'b1, sdat: 1'b0};
    localparam ctl3_lines_t LINES_MARK = '{mode: 1'b0, sclk: 1'b1, sdat: 1'b0};

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [DEV_W-1:0] dev,
                                                    input logic [SEL_W-1:0] sel);
        return {dev, sel};
    endfunction

    function automatic ctl3_lines_t bit_lines(input logic data_phase,
                                              input logic high_half,
                                              input logic b);
        return '{mode: data_phase, sclk: high_half, sdat: b};
    endfunction

endpackage

// File: rtl/ctl3_phase_timer.sv
module ctl3_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q == len_i - ONE);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R4: the count never runs past the length of the phase it times
    assert_cnt_in_phase_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q < len_i);

endmodule

// File: rtl/ctl3_bit_shifter.sv
module ctl3_bit_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  logic         advance,
    output logic         bit_o,
    output logic         last_bit
);
    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    logic [W-1:0]     data_q;
    logic [IDX_W-1:0] idx_q;

    assign bit_o    = data_q[0];
    assign last_bit = (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            data_q <= load_byte;
            idx_q  <= '0;
        end else if (advance) begin
            data_q <= {1'b0, data_q[W-1:1]};
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // R4: a byte is never stepped beyond its final bit
    assert_no_ninth_bit_R4: assert property (@(posedge clk) disable iff (rst)
        advance |-> (idx_q != IDX_LAST));

    // R4: a new byte always starts at bit 0
    assert_load_starts_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx_q == '0));

endmodule

// File: rtl/ctl3_seq.sv
module ctl3_seq
    import ctl3_pkg::*;
#(
    parameter int                SETUP_CYC = 20,
    parameter int                HALF_CYC  = 50,
    parameter int                CNT_W     = 6,
    parameter logic [DEV_W-1:0]  DEV_CODE  = 6'b000101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_halt,
    input  logic              cmd_last,
    input  logic              tmr_expire,
    output logic              tmr_restart,
    output logic [CNT_W-1:0]  tmr_len,
    input  logic              sh_bit,
    input  logic              sh_last,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_byte,
    output logic              sh_adv,
    output ctl3_lines_t       lines,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] LEN_SETUP = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] LEN_HALF  = CNT_W'(HALF_CYC);
    localparam logic [CNT_W-1:0] LEN_WAIT  = CNT_W'(1);

    ctl3_state_e state_q, state_nx;
    logic        addr_q, addr_nx;
    logic        final_q, final_nx;
    logic        take;

    assign cmd_ready = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign take      = cmd_valid && cmd_ready;
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);

    always_comb begin
        state_nx = state_q;
        addr_nx  = addr_q;
        final_nx = final_q;
        sh_load  = 1'b0;
        sh_byte  = cmd_data;
        sh_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    sh_load  = 1'b1;
                    sh_byte  = addr_byte(DEV_CODE, cmd_data[SEL_W-1:0]);
                    addr_nx  = 1'b1;
                    final_nx = 1'b0;
                    state_nx = ST_ASETUP;
                end
            end
            ST_ASETUP: if (tmr_expire) state_nx = ST_BLO;
            ST_BLO:    if (tmr_expire) state_nx = ST_BHI;
            ST_BHI: begin
                if (tmr_expire) begin
                    if (!sh_last) begin
                        sh_adv   = 1'b1;
                        state_nx = ST_BLO;
                    end else if (addr_q || !final_q) begin
                        state_nx = ST_GAP;
                    end else begin
                        state_nx = ST_FIN;
                    end
                end
            end
            ST_GAP: begin
                if (take) begin
                    sh_load  = 1'b1;
                    addr_nx  = 1'b0;
                    final_nx = cmd_last;
                    state_nx = cmd_halt ? ST_HALT : ST_DSETUP;
                end
            end
            ST_HALT:   if (tmr_expire) state_nx = ST_DSETUP;
            ST_DSETUP: if (tmr_expire) state_nx = ST_BLO;
            ST_FIN:    state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign tmr_restart = (state_nx != state_q);

    always_comb begin
        unique case (state_q)
            ST_ASETUP, ST_HALT, ST_DSETUP: tmr_len = LEN_SETUP;
            ST_BLO, ST_BHI:                tmr_len = LEN_HALF;
            default:                       tmr_len = LEN_WAIT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_ASETUP, ST_HALT: lines = LINES_MARK;
            ST_BLO:             lines = bit_lines(!addr_q, 1'b0, sh_bit);
            ST_BHI:             lines = bit_lines(!addr_q, 1'b1, sh_bit);
            default:            lines = LINES_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= 1'b0;
            final_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            addr_q  <= addr_nx;
            final_q <= final_nx;
        end
    end

    // R8: completion is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a command only starts from an offered beat
    assert_busy_needs_beat_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

endmodule

// File: rtl/ctl3_master.sv
module ctl3_master
    import ctl3_pkg::*;
#(
    parameter int               SETUP_CYC = 20,
    parameter int               HALF_CYC  = 50,
    parameter logic [5:0]       DEV_CODE  = 6'b000101
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_data,
    input  logic       cmd_halt,
    input  logic       cmd_last,
    output logic       line_mode,
    output logic       line_clk,
    output logic       line_data,
    output logic       busy,
    output logic       done
);
    localparam int MAX_CYC = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              tmr_expire;
    logic              tmr_restart;
    logic [CNT_W-1:0]  tmr_len;
    logic              sh_bit;
    logic              sh_last;
    logic              sh_load;
    logic              sh_adv;
    logic [BYTE_W-1:0] sh_byte;
    ctl3_lines_t       lines;

    ctl3_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HALF_CYC  (HALF_CYC),
        .CNT_W     (CNT_W),
        .DEV_CODE  (DEV_CODE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_data    (cmd_data),
        .cmd_halt    (cmd_halt),
        .cmd_last    (cmd_last),
        .tmr_expire  (tmr_expire),
        .tmr_restart (tmr_restart),
        .tmr_len     (tmr_len),
        .sh_bit      (sh_bit),
        .sh_last     (sh_last),
        .sh_load     (sh_load),
        .sh_byte     (sh_byte),
        .sh_adv      (sh_adv),
        .lines       (lines),
        .busy        (busy),
        .done        (done)
    );

    ctl3_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .len_i   (tmr_len),
        .expire  (tmr_expire)
    );

    ctl3_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (sh_byte),
        .advance   (sh_adv),
        .bit_o     (sh_bit),
        .last_bit  (sh_last)
    );

    assign line_mode = lines.mode;
    assign line_clk  = lines.sclk;
    assign line_data = lines.sdat;

    // R4: the serial clock only moves when a timed phase has run out
    assert_clk_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_clk) |-> $past(tmr_expire));

endmodule

// File: tb/ctl3_master_test.sv
module ctl3_master_test;

    localparam int S = 3;
    localparam int H = 2;
    localparam logic [5:0] DEV = 6'b000101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_halt = 1'b0;
    logic       cmd_last = 1'b0;
    logic       cmd_ready, line_mode, line_clk, line_data, busy, done;

    int checks = 0;
    int bad = 0;

    logic [7:0] dbyte [4];
    logic       dhalt [4];

    always #5 clk = ~clk;

    ctl3_master #(.SETUP_CYC(S), .HALF_CYC(H), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_halt(cmd_halt), .cmd_last(cmd_last),
        .line_mode(line_mode), .line_clk(line_clk), .line_data(line_data),
        .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // status word: {mode, clk, data, ready, busy, done}
    function automatic logic [5:0] status();
        return {line_mode, line_clk, line_data, cmd_ready, busy, done};
    endfunction

    task automatic phase(input string tag, input logic m, input logic c,
                         input logic d, input int n);
        int errs = 0;
        logic [5:0] got = '0;
        logic [5:0] exp = {m, c, d, 1'b0, 1'b1, 1'b0};
        for (int k = 0; k < n; k++) begin
            if (status() !== exp) begin
                errs++;
                got = status();
            end
            @(negedge clk);
        end
        checks++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input logic m, input bit junk);
        for (int i = 0; i < 8; i++) begin
            if (junk && i == 0) begin
                cmd_valid = 1'b1;
                cmd_data  = 8'hA5;
            end
            if (junk && i == 7) cmd_valid = 1'b0;
            phase(m ? "R4/R5/R9 data bit low half" : "R3/R4/R5/R9 address bit low half",
                  m, 1'b0, b[i], H);
            phase(m ? "R4/R5 data bit high half" : "R3/R4/R5 address bit high half",
                  m, 1'b1, b[i], H);
        end
    endtask

    task automatic run_cmd(input logic [1:0] sel, input int nb, input int stall,
                           input bit junk);
        chk("R1 idle before command", {26'd0, status()}, {26'd0, 6'b110_1_0_0});
        cmd_valid = 1'b1;
        cmd_data  = {6'b101010, sel};
        cmd_halt  = 1'b1;
        cmd_last  = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        phase("R2 address setup", 1'b0, 1'b1, 1'b0, S);
        send_bits({DEV, sel}, 1'b0, junk);
        for (int j = 0; j < nb; j++) begin
            for (int w = 0; w < stall; w++) begin
                chk("R6 rest between bytes", {26'd0, status()}, {26'd0, 6'b110_1_1_0});
                @(negedge clk);
            end
            chk("R6 ready between bytes", {26'd0, status()}, {26'd0, 6'b110_1_1_0});
            cmd_valid = 1'b1;
            cmd_data  = dbyte[j];
            cmd_halt  = dhalt[j];
            cmd_last  = (j == nb - 1);
            @(negedge clk);
            cmd_valid = 1'b0;
            if (dhalt[j]) phase("R7 halt interval", 1'b0, 1'b1, 1'b0, S);
            phase("R7 data setup", 1'b1, 1'b1, 1'b0, S);
            send_bits(dbyte[j], 1'b1, 1'b0);
        end
        chk("R8 done pulse with lines at rest", {26'd0, status()}, {26'd0, 6'b110_0_1_1});
        @(negedge clk);
        chk("R8 idle after done", {26'd0, status()}, {26'd0, 6'b110_1_0_0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", {26'd0, status()}, {26'd0, 6'b110_1_0_0});
        for (int c = 0; c < 64; c++) begin
            for (int j = 0; j < 4; j++) begin
                dbyte[j] = 8'(c * 4 + j);
                dhalt[j] = dbyte[j][0] ^ dbyte[j][3];
            end
            run_cmd(2'(c % 4), 4, c % 3, (c % 5) == 0);
        end
        dbyte[0] = 8'h81;
        dhalt[0] = 1'b0;
        run_cmd(2'b10, 1, 0, 1'b1);
        dbyte[0] = 8'h4D;
        dhalt[0] = 1'b1;
        run_cmd(2'b00, 1, 5, 1'b0);
        repeat (4) begin
            @(negedge clk);
            chk("R1 stays idle", {26'd0, status()}, {26'd0, 6'b110_1_0_0});
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule